// File: doc/BRIEF.md
# Byte-Serial SPI Master with Register Interface

This block drives one SPI bus from a small 32-bit register window. Software picks one of several chip-select lines and turns it on, chooses clock polarity, clock phase and the order in which bits leave and arrive, and sets a two-stage clock prescaler. A write to the transmit-data register launches one 8-bit full-duplex exchange. When the eighth bit has been sampled, the received byte is placed in the receive-data register and the interrupt-cause flag is set. Software polls the ready bit or the cause flag, reads the byte, and clears the flag by writing zero to it.

The register port uses a valid/ready handshake. `bus_ready` is held high, so every beat is accepted in the cycle it is offered and there is no back-pressure. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. Read data is combinational: it appears on `bus_rdata` in the same cycle as a read beat and is zero in any other cycle. Chip select is driven only from the enable bit and the select number. It is never pulsed between bytes, so a multi-byte command is built by leaving it enabled across several launches.

Top module: `spi_byte_master`

## Requirements
- R1: After reset all chip selects are high, SCLK is low, the control register reads 0x2 (idle, select disabled), and the configuration, receive-data and cause registers read 0.
- R2: Byte offsets are 0x00 control, 0x04 configuration, 0x08 transmit data, 0x0C receive data, 0x10 cause. Configuration fields are: prescale factor bits 3:0, exponent bit 0 at bit 4, exponent bits 2:1 at bits 7:6, polarity bit 11, phase bit 12, transmit LSB-first bit 13, receive LSB-first bit 14. Bit 5 (transfer length) reads 0, so only 8-bit transfers exist, and the writable mask is 0x78DF.
- R3: Control bit 0 enables the select and bits 4:2 hold its number. `spi_cs_n[k]` is low only when the select is enabled and its number is k, and it stays constant for the whole of each transfer and between transfers.
- R4: With factor F (1..15) and exponent E (0..7), one SCLK period lasts max(F·2^E, 2) core cycles and a transfer keeps the ready bit at 0 for exactly eight periods.
- R5: Idle SCLK equals the polarity bit. With phase 0, MISO is sampled on the leading edge of each bit and MOSI changes on the trailing edge. With phase 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Each transfer has 16 SCLK edges.
- R6: With transmit LSB-first set, bit 0 of the written byte goes out first on MOSI. With it clear, bit 7 goes out first.
- R7: With receive LSB-first set, the first bit sampled lands in bit 0 of the received byte. With it clear, it lands in bit 7.
- R8: Writing the transmit register while idle starts a transfer. Control bit 1 (ready) reads 0 while shifting and 1 when idle. On completion the receive register holds the byte and the cause register reads 1.
- R9: A transmit-register write during a transfer is ignored: the byte on the wire, the transfer length and the transmit register read-back are all unchanged.
- R10: While the prescale factor is 0, transmit writes start nothing: ready stays 1, SCLK does not toggle, cause stays 0 and the transmit register keeps its old value.
- R11: Writing 0 to the cause register clears it. Writing any non-zero value leaves it unchanged.
- R12: `bus_ready` is always 1, an unmapped offset reads 0, and writes to the receive register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register beat offered |
| bus_ready | output | 1 | Beat accepted (always high) |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read beat |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | N_CS | Active-low chip selects |

## Verification
The bench builds the block with its default of eight chip selects and the fixed field widths of a 4-bit factor and a 3-bit exponent, so every select number and divisors from the clamped minimum of 2 up to 1920 can be reached. Directed transfers cover the clamp case, an odd divisor, an exponent whose upper bits sit in bits 7:6, and the largest divisor. Random transfers then mix all four clock modes, both bit orders in each direction, random selects and random data against a device model that shifts on the edges the phase setting calls for.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [4:0] OFF_CTRL  = 5'h00;
  localparam logic [4:0] OFF_CFG   = 5'h04;
  localparam logic [4:0] OFF_TXD   = 5'h08;
  localparam logic [4:0] OFF_RXD   = 5'h0C;
  localparam logic [4:0] OFF_CAUSE = 5'h10;

  localparam int FACT_W  = 4;
  localparam int EXPO_W  = 3;
  localparam int DIV_W   = FACT_W + (1 << EXPO_W) - 1;

  localparam int B_CSEN   = 0;
  localparam int B_READY  = 1;
  localparam int B_CSNUM  = 2;
  localparam int B_EXPO0  = 4;
  localparam int B_EXPOHI = 6;
  localparam int B_CPOL   = 11;
  localparam int B_CPHA   = 12;
  localparam int B_TXLSB  = 13;
  localparam int B_RXLSB  = 14;

  function automatic logic [7:0] flip8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction
endpackage

// File: rtl/spim_prescale.sv
module spim_prescale
  import spim_pkg::*;
(
  input  logic [FACT_W-1:0] fact,
  input  logic [EXPO_W-1:0] expo,
  output logic [DIV_W-1:0]  lo_len,
  output logic [DIV_W-1:0]  hi_len,
  output logic              legal
);
  logic [DIV_W-1:0] div_raw;
  logic [DIV_W-1:0] div_eff;

  always_comb begin
    div_raw = DIV_W'(fact) << expo;
    div_eff = (div_raw < DIV_W'(2)) ? DIV_W'(2) : div_raw;
    lo_len  = div_eff >> 1;
    hi_len  = div_eff - lo_len;
    legal   = (fact != '0);
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic             cpol_live,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             tx_lsb,
  input  logic             rx_lsb,
  input  logic [DIV_W-1:0] lo_len,
  input  logic [DIV_W-1:0] hi_len,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_word,
  output logic             sclk,
  output logic             mosi
);
  logic             busy_q, act_q, cpol_q, cpha_q, rxl_q;
  logic [3:0]       hidx_q;
  logic [DIV_W-1:0] hcnt_q, lo_q, hi_q;
  logic [7:0]       tx_q, rx_q, rx_nxt;
  logic             edge_now, last, samp, shft;

  always_comb begin
    edge_now = busy_q && (hcnt_q == '0);
    last     = (hidx_q == 4'd15);
    samp     = (hidx_q[0] == cpha_q);
    shft     = !samp && !(!cpha_q && last) && !(cpha_q && hidx_q == 4'd0);
    rx_nxt   = samp ? {rx_q[6:0], miso} : rx_q;
    done     = edge_now && last;
    rx_word  = rxl_q ? flip8(rx_nxt) : rx_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; act_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; rxl_q <= 1'b0;
      hidx_q <= '0; hcnt_q <= '0; lo_q <= '0; hi_q <= '0; tx_q <= '0; rx_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        act_q  <= 1'b0;
        hidx_q <= '0;
        hcnt_q <= lo_len - DIV_W'(1);
        lo_q   <= lo_len;
        hi_q   <= hi_len;
        tx_q   <= tx_lsb ? flip8(tx_byte) : tx_byte;
        rx_q   <= '0;
        cpol_q <= cpol;
        cpha_q <= cpha;
        rxl_q  <= rx_lsb;
      end
    end else if (edge_now) begin
      act_q  <= ~act_q;
      hidx_q <= hidx_q + 4'd1;
      rx_q   <= rx_nxt;
      if (shft) tx_q <= {tx_q[6:0], 1'b0};
      hcnt_q <= (hidx_q[0] ? lo_q : hi_q) - DIV_W'(1);
      if (last) busy_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_q - DIV_W'(1);
    end
  end

  assign busy = busy_q;
  assign sclk = busy_q ? (cpol_q ^ act_q) : cpol_live;
  assign mosi = tx_q[7];

  // R5: clock level and outgoing bit only move on a half-period boundary
  assert_hold_between_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && hcnt_q != '0) |=> ($stable(tx_q) && $stable(act_q)));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int N_CS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  output logic            bus_ready,
  input  logic            bus_write,
  input  logic [4:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            spi_sclk,
  output logic            spi_mosi,
  input  logic            spi_miso,
  output logic [N_CS-1:0] spi_cs_n
);
  localparam int CS_W = (N_CS > 1) ? $clog2(N_CS) : 1;

  logic              cs_en_q, cpol_q, cpha_q, txl_q, rxl_q, cause_q;
  logic [CS_W-1:0]   cs_num_q;
  logic [FACT_W-1:0] fact_q;
  logic [EXPO_W-1:0] expo_q;
  logic [7:0]        txd_q, rxd_q;
  logic [DIV_W-1:0]  lo_len, hi_len;
  logic              legal, busy_w, done_w, wr, start_ok;
  logic [7:0]        rx_word;

  assign bus_ready = 1'b1;
  assign wr        = bus_valid && bus_write;
  assign start_ok  = wr && (bus_addr == OFF_TXD) && !busy_w && legal;

  spim_prescale u_presc (
    .fact(fact_q), .expo(expo_q), .lo_len(lo_len), .hi_len(hi_len), .legal(legal)
  );

  spim_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .tx_byte(bus_wdata[7:0]),
    .cpol_live(cpol_q), .cpol(cpol_q), .cpha(cpha_q), .tx_lsb(txl_q), .rx_lsb(rxl_q),
    .lo_len(lo_len), .hi_len(hi_len), .miso(spi_miso),
    .busy(busy_w), .done(done_w), .rx_word(rx_word), .sclk(spi_sclk), .mosi(spi_mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en_q <= 1'b0; cs_num_q <= '0; fact_q <= '0; expo_q <= '0;
      cpol_q <= 1'b0; cpha_q <= 1'b0; txl_q <= 1'b0; rxl_q <= 1'b0;
      txd_q <= '0; rxd_q <= '0; cause_q <= 1'b0;
    end else begin
      if (wr && bus_addr == OFF_CTRL) begin
        cs_en_q  <= bus_wdata[B_CSEN];
        cs_num_q <= bus_wdata[B_CSNUM +: CS_W];
      end
      if (wr && bus_addr == OFF_CFG) begin
        fact_q <= bus_wdata[FACT_W-1:0];
        expo_q <= {bus_wdata[B_EXPOHI +: 2], bus_wdata[B_EXPO0]};
        cpol_q <= bus_wdata[B_CPOL];
        cpha_q <= bus_wdata[B_CPHA];
        txl_q  <= bus_wdata[B_TXLSB];
        rxl_q  <= bus_wdata[B_RXLSB];
      end
      if (start_ok) txd_q <= bus_wdata[7:0];
      if (done_w) begin
        rxd_q   <= rx_word;
        cause_q <= 1'b1;
      end else if (wr && bus_addr == OFF_CAUSE && bus_wdata == '0) begin
        cause_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        OFF_CTRL: begin
          bus_rdata[B_CSEN]           = cs_en_q;
          bus_rdata[B_READY]          = !busy_w;
          bus_rdata[B_CSNUM +: CS_W]  = cs_num_q;
        end
        OFF_CFG: begin
          bus_rdata[FACT_W-1:0]       = fact_q;
          bus_rdata[B_EXPO0]          = expo_q[0];
          bus_rdata[B_EXPOHI +: 2]    = expo_q[2:1];
          bus_rdata[B_CPOL]           = cpol_q;
          bus_rdata[B_CPHA]           = cpha_q;
          bus_rdata[B_TXLSB]          = txl_q;
          bus_rdata[B_RXLSB]          = rxl_q;
        end
        OFF_TXD:   bus_rdata[7:0] = txd_q;
        OFF_RXD:   bus_rdata[7:0] = rxd_q;
        OFF_CAUSE: bus_rdata[0]   = cause_q;
        default:   bus_rdata      = '0;
      endcase
    end
  end

  for (genvar g = 0; g < N_CS; g++) begin : g_cs
    assign spi_cs_n[g] = !(cs_en_q && cs_num_q == CS_W'(g));
  end

  // R3: never more than one select active
  assert_one_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  // R8: cause is raised exactly as the shifter goes idle
  assert_cause_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q) |-> $fell(busy_w));
  // R9: a launch during a transfer leaves the transmit register alone
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && wr && bus_addr == OFF_TXD) |=> $stable(txd_q));
  // R10: zero factor never starts the shifter
  assert_no_start_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && fact_q == '0) |=> !busy_w);
endmodule

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/1ps
module spi_byte_master_bench;
  import spim_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [7:0]  spi_cs_n;

  always #2 clk = ~clk;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // Device model
  logic       sl_on = 1'b0;
  bit         sl_cpha = 1'b0;
  int         sl_n = 0;
  logic [7:0] sl_tx = '0, sl_rx = '0;
  assign spi_miso = sl_tx[7];

  always @(spi_sclk) begin
    if (sl_on) begin
      sl_n++;
      if (((sl_n % 2) == 1) == (sl_cpha == 1'b0)) sl_rx = {sl_rx[6:0], spi_mosi};
      else if ((!sl_cpha && sl_n < 16) || (sl_cpha && sl_n > 1)) sl_tx = {sl_tx[6:0], 1'b0};
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  function automatic int exp_div(input logic [31:0] cfg);
    int d;
    d = int'(cfg[3:0]) << int'({cfg[7:6], cfg[4]});
    return (d < 2) ? 2 : d;
  endfunction

  task automatic xfer(input logic [31:0] cfg, input logic [7:0] tx, input logic [7:0] sb,
                      input bit dbl, input logic [7:0] tx2, input logic [7:0] cs_exp);
    logic [31:0] v;
    int cnt, cs_bad;
    wr(OFF_CFG, cfg);
    wr(OFF_CAUSE, 32'h0);
    sl_cpha = cfg[B_CPHA]; sl_tx = sb; sl_rx = '0; sl_n = 0; sl_on = 1'b1;
    cnt = 0; cs_bad = 0;
    wr(OFF_TXD, {24'h0, tx});
    if (dbl) begin wr(OFF_TXD, {24'h0, tx2}); cnt = 1; end
    forever begin
      rd(OFF_CTRL, v);
      if (spi_cs_n != cs_exp) cs_bad++;
      if (v[B_READY]) break;
      cnt++;
    end
    sl_on = 1'b0;
    check(cnt == 8 * exp_div(cfg), "R4 transfer length", cnt, 8 * exp_div(cfg));
    check(sl_n == 16, "R5 edge count", sl_n, 16);
    check(cs_bad == 0, "R3 select held", cs_bad, 0);
    check(sl_rx == (cfg[B_TXLSB] ? flip8(tx) : tx), "R6 wire order", sl_rx, cfg[B_TXLSB] ? flip8(tx) : tx);
    rd(OFF_RXD, v);
    check(v[7:0] == (cfg[B_RXLSB] ? flip8(sb) : sb), "R7 received byte", v, cfg[B_RXLSB] ? flip8(sb) : sb);
    rd(OFF_CAUSE, v);
    check(v == 32'h1, "R8 cause set", v, 1);
    if (dbl) begin
      rd(OFF_TXD, v);
      check(v == {24'h0, tx}, "R9 busy write ignored", v, tx);
    end
  endtask

  initial begin
    logic [31:0] v, keep;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check(spi_cs_n == 8'hFF, "R1 selects high", spi_cs_n, 8'hFF);
    check(spi_sclk == 1'b0, "R1 sclk low", spi_sclk, 0);
    rd(OFF_CTRL, v);  check(v == 32'h2, "R1 control", v, 2);
    rd(OFF_CFG, v);   check(v == 32'h0, "R1 config", v, 0);
    rd(OFF_RXD, v);   check(v == 32'h0, "R1 receive", v, 0);
    rd(OFF_CAUSE, v); check(v == 32'h0, "R1 cause", v, 0);
    check(bus_ready == 1'b1, "R12 ready high", bus_ready, 1);

    wr(OFF_CFG, 32'hFFFF_FFFF);
    rd(OFF_CFG, v); check(v == 32'h78DF, "R2 config mask", v, 32'h78DF);

    // Zero factor: start must be refused
    wr(OFF_CFG, 32'h0000_0800);
    check(spi_sclk == 1'b1, "R5 idle polarity", spi_sclk, 1);
    sl_n = 0; sl_on = 1'b1;
    wr(OFF_TXD, 32'h3C);
    keep = 32'h2;
    for (int i = 0; i < 10; i++) begin
      rd(OFF_CTRL, v);
      if (!v[B_READY]) keep = v;
    end
    sl_on = 1'b0;
    check(keep == 32'h2, "R10 stays ready", keep, 2);
    check(sl_n == 0, "R10 no sclk", sl_n, 0);
    rd(OFF_CAUSE, v); check(v == 32'h0, "R10 no cause", v, 0);
    rd(OFF_TXD, v);   check(v == 32'h0, "R10 txd kept", v, 0);

    wr(OFF_CTRL, 32'h15);
    check(spi_cs_n == 8'hDF, "R3 select five", spi_cs_n, 8'hDF);
    rd(OFF_CTRL, v); check(v == 32'h17, "R3 control readback", v, 32'h17);

    xfer(32'h0000_0001, 8'hA5, 8'h3C, 1'b0, 8'h00, 8'hDF);
    xfer(32'h0000_0003, 8'h96, 8'hC3, 1'b0, 8'h00, 8'hDF);
    xfer(32'h0000_3813, 8'h01, 8'h80, 1'b0, 8'h00, 8'hDF);
    xfer(32'h0000_50C5, 8'h5A, 8'h0F, 1'b0, 8'h00, 8'hDF);
    xfer(32'h0000_08DF, 8'hE1, 8'h71, 1'b0, 8'h00, 8'hDF);
    xfer(32'h0000_0002, 8'h81, 8'h66, 1'b1, 8'h7E, 8'hDF);

    wr(OFF_CAUSE, 32'h5);
    rd(OFF_CAUSE, v); check(v == 32'h1, "R11 nonzero write kept", v, 1);
    wr(OFF_CAUSE, 32'h0);
    rd(OFF_CAUSE, v); check(v == 32'h0, "R11 zero write clears", v, 0);

    rd(OFF_RXD, keep);
    wr(OFF_RXD, 32'hFF);
    rd(OFF_RXD, v); check(v == keep, "R12 receive read-only", v, keep);
    rd(5'h14, v);   check(v == 32'h0, "R12 unmapped reads zero", v, 0);

    for (int k = 0; k < 24; k++) begin
      logic [31:0] cfg;
      logic [2:0]  num, ex;
      num = 3'($urandom % 8);
      ex  = 3'($urandom % 3);
      cfg = 32'(1 + $urandom % 4);
      cfg[B_EXPO0] = ex[0];
      cfg[B_EXPOHI +: 2] = ex[2:1];
      cfg[B_CPOL]  = 1'($urandom);
      cfg[B_CPHA]  = 1'($urandom);
      cfg[B_TXLSB] = 1'($urandom);
      cfg[B_RXLSB] = 1'($urandom);
      wr(OFF_CTRL, {27'h0, num, 2'b01});
      xfer(cfg, 8'($urandom), 8'($urandom), 1'b0, 8'h00, ~(8'h01 << num));
    end

    wr(OFF_CTRL, 32'h14);
    check(spi_cs_n == 8'hFF, "R3 select disabled", spi_cs_n, 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule